// File: doc/BRIEF.md
# Microprogram Sequencer with Instruction Dispatch

This block produces the 9-bit microprogram address for a microcoded processor. The address selects one word in an external control store. Each microword supplies the address of its successor, so every step carries an implicit goto. A 2-bit branch selector in the same word chooses how that address is used:
- taken as it is;
- with a test condition ORed into its lowest bit;
- with a dispatch value from the instruction decoder laid over it;
- or held until the bus slave acknowledges a pending read, as in an instruction fetch step.

Each clock edge stands for one microstep boundary. Address 000 is where every instruction ends. At that address, pending trap, interrupt and error flags are polled. Any set flag sends the sequencer to a service entry and overrides the microword. A power-up init input stops the sequencer and forces address 001, the start of the power-up microprogram. The first step after init is released still presents 001. The advance begins on the edge after that.

The sequencer is built around a three-state controller:
- INIT is held while power-up init is asserted.
- RUN is the normal state. Each edge loads the computed next address.
- BUSWAIT is entered from RUN when a fetch step finds no acknowledge. The address is frozen in this state.

Named transitions:
- INIT→RUN on the first edge with init low.
- RUN→BUSWAIT on a fetch without acknowledge.
- BUSWAIT→RUN on acknowledge.
- Any state→INIT whenever init is high.

Top module: `useq_top`

## Requirements
- R1: While `pwr_init` is high at a clock edge, `upc` becomes 001 and `stalled` becomes 0. On the first edge with `pwr_init` low, `upc` stays 001. Advancing starts on the edge after that.
- R2: With `br_sel` = 2'b00 (goto) and no poll override, the next `upc` equals `nxt_addr`. `test_in` and `disp_val` have no effect.
- R3: With `br_sel` = 2'b01 (test), the next `upc` equals `nxt_addr` with bit 0 ORed with `test_in`.
- R4: With `br_sel` = 2'b10 (dispatch), the next `upc` equals `nxt_addr` bitwise ORed with `disp_val`.
- R5: With `br_sel` = 2'b11 (fetch) and `bus_ack` high at the edge, the next `upc` equals `nxt_addr` in one step, and `stalled` stays 0.
- R6: With `br_sel` = 2'b11 and `bus_ack` low, `upc` holds and `stalled` becomes 1. Both stay that way at every edge with `bus_ack` low. At the first edge with `bus_ack` high, `upc` takes `nxt_addr` and `stalled` returns to 0.
- R7: When `upc` is 000 and any bit of `flags` is set, the next `upc` is `SVC_BASE` ORed with the index of the lowest set flag, whatever the microword says (default `SVC_BASE` = 9'h100). At any other address, `flags` have no effect.
- R8: Asserting `pwr_init` during a bus wait abandons the wait. `upc` becomes 001 and `stalled` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; each rising edge ends a microstep |
| pwr_init | input | 1 | Power-up init, active high; holds the sequencer at 001 |
| nxt_addr | input | 9 | Next-address field of the current microword |
| br_sel | input | 2 | Branch selector: 00 goto, 01 test, 10 dispatch, 11 fetch wait |
| test_in | input | 1 | Selected micro-test condition |
| disp_val | input | 9 | Dispatch value from the instruction decoder |
| flags | input | 3 | Pending trap, interrupt and error flags; bit 0 has highest priority |
| bus_ack | input | 1 | Bus slave acknowledge for a pending read |
| upc | output | 9 | Microprogram address to the control store |
| stalled | output | 1 | High while the clock is held waiting for the bus acknowledge |

## Verification
The assertions check these on every cycle:
- forcing of 001 under init;
- the frozen address and raised stall flag while a fetch lacks an acknowledge;
- release from the wait on acknowledge;
- plain goto sequencing;
- the landing in the service range when the poll at 000 sees a flag.

Only the bench's scenarios can show:
- the exact ORed addresses of test and dispatch branches;
- the priority between several flags;
- flags being ignored away from 000;
- the one-step hold of 001 after init release;
- a whole instruction loop of fetch, increment-and-dispatch, execute and poll returning to the fetch.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [1:0] {
        SEQ_INIT    = 2'd0,
        SEQ_RUN     = 2'd1,
        SEQ_BUSWAIT = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        BR_GOTO     = 2'b00,
        BR_TEST     = 2'b01,
        BR_DISPATCH = 2'b10,
        BR_FETCH    = 2'b11
    } br_sel_t;

endpackage

// File: rtl/useq_poll.sv
module useq_poll #(
    parameter int NFLAG = 3,
    parameter int IW    = (NFLAG > 1) ? $clog2(NFLAG) : 1
) (
    input  logic [NFLAG-1:0] flags,
    output logic             hit,
    output logic [IW-1:0]    idx
);
    // Lowest-numbered set flag wins.
    always_comb begin
        idx = '0;
        for (int i = NFLAG - 1; i >= 0; i--) begin
            if (flags[i]) idx = IW'(i);
        end
        hit = |flags;
    end
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
#(
    parameter int             AW       = 9,
    parameter int             IW       = 2,
    parameter logic [AW-1:0]  SVC_BASE = 9'h100
) (
    input  logic [1:0]    br_sel,
    input  logic [AW-1:0] nxt_addr,
    input  logic          test_in,
    input  logic [AW-1:0] disp_val,
    input  logic          at_poll,
    input  logic          poll_hit,
    input  logic [IW-1:0] poll_idx,
    output logic [AW-1:0] target,
    output logic          wait_req
);
    logic take_svc;

    always_comb begin
        take_svc = at_poll && poll_hit;
        target   = nxt_addr;
        if (take_svc) begin
            target = SVC_BASE | AW'(poll_idx);
        end else begin
            unique case (br_sel_t'(br_sel))
                BR_GOTO:     target = nxt_addr;
                BR_TEST:     target = {nxt_addr[AW-1:1], nxt_addr[0] | test_in};
                BR_DISPATCH: target = nxt_addr | disp_val;
                BR_FETCH:    target = nxt_addr;
                default:     target = nxt_addr;
            endcase
        end
        wait_req = (br_sel_t'(br_sel) == BR_FETCH) && !take_svc;
    end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
(
    input  logic clk,
    input  logic pwr_init,
    input  logic wait_req,
    input  logic bus_ack,
    output logic load,
    output logic stalled,
    output logic st_run
);
    seq_state_t state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (pwr_init) state <= SEQ_INIT;
        else          state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_INIT:    state_nx = SEQ_RUN;
            SEQ_RUN:     state_nx = (wait_req && !bus_ack) ? SEQ_BUSWAIT : SEQ_RUN;
            SEQ_BUSWAIT: state_nx = bus_ack ? SEQ_RUN : SEQ_BUSWAIT;
            default:     state_nx = SEQ_INIT;
        endcase
    end

    // Outputs
    always_comb begin
        load    = 1'b0;
        stalled = 1'b0;
        st_run  = 1'b0;
        unique case (state)
            SEQ_INIT:    ;
            SEQ_RUN: begin
                st_run = 1'b1;
                load   = !(wait_req && !bus_ack);
            end
            SEQ_BUSWAIT: begin
                stalled = 1'b1;
                load    = bus_ack;
            end
            default:     ;
        endcase
    end
endmodule

// File: rtl/useq_top.sv
module useq_top
    import useq_pkg::*;
#(
    parameter int            AW        = 9,
    parameter int            NFLAG     = 3,
    parameter logic [AW-1:0] INIT_ADDR = 9'h001,
    parameter logic [AW-1:0] POLL_ADDR = 9'h000,
    parameter logic [AW-1:0] SVC_BASE  = 9'h100
) (
    input  logic             clk,
    input  logic             pwr_init,
    input  logic [AW-1:0]    nxt_addr,
    input  logic [1:0]       br_sel,
    input  logic             test_in,
    input  logic [AW-1:0]    disp_val,
    input  logic [NFLAG-1:0] flags,
    input  logic             bus_ack,
    output logic [AW-1:0]    upc,
    output logic             stalled
);
    localparam int IW = (NFLAG > 1) ? $clog2(NFLAG) : 1;

    logic          poll_hit;
    logic [IW-1:0] poll_idx;
    logic [AW-1:0] target;
    logic          wait_req;
    logic          load;
    logic          st_run;

    useq_poll #(.NFLAG(NFLAG), .IW(IW)) u_poll (
        .flags (flags),
        .hit   (poll_hit),
        .idx   (poll_idx)
    );

    useq_nextaddr #(.AW(AW), .IW(IW), .SVC_BASE(SVC_BASE)) u_nxt (
        .br_sel   (br_sel),
        .nxt_addr (nxt_addr),
        .test_in  (test_in),
        .disp_val (disp_val),
        .at_poll  (upc == POLL_ADDR),
        .poll_hit (poll_hit),
        .poll_idx (poll_idx),
        .target   (target),
        .wait_req (wait_req)
    );

    useq_ctrl u_ctrl (
        .clk      (clk),
        .pwr_init (pwr_init),
        .wait_req (wait_req),
        .bus_ack  (bus_ack),
        .load     (load),
        .stalled  (stalled),
        .st_run   (st_run)
    );

    always_ff @(posedge clk) begin
        if (pwr_init)  upc <= INIT_ADDR;
        else if (load) upc <= target;
    end
endmodule

// File: rtl/useq_chk.sv
module useq_chk #(
    parameter int            AW        = 9,
    parameter int            NFLAG     = 3,
    parameter logic [AW-1:0] INIT_ADDR = 9'h001,
    parameter logic [AW-1:0] SVC_BASE  = 9'h100
) (
    input logic             clk,
    input logic             pwr_init,
    input logic [AW-1:0]    nxt_addr,
    input logic [1:0]       br_sel,
    input logic [NFLAG-1:0] flags,
    input logic             bus_ack,
    input logic [AW-1:0]    upc,
    input logic             stalled,
    input logic             st_run
);
    localparam int IW = (NFLAG > 1) ? $clog2(NFLAG) : 1;

    // R1 / R8
    p_init_forces_start_r1: assert property (@(posedge clk)
        pwr_init |=> (upc == INIT_ADDR) && !stalled);

    // R2
    p_goto_follows_field_r2: assert property (@(posedge clk) disable iff (pwr_init)
        (st_run && br_sel == 2'b00 && upc != '0) |=> upc == $past(nxt_addr));

    // R6
    p_fetch_enters_wait_r6: assert property (@(posedge clk) disable iff (pwr_init)
        (st_run && br_sel == 2'b11 && !bus_ack && upc != '0) |=> stalled && $stable(upc));

    // R6
    p_wait_holds_r6: assert property (@(posedge clk) disable iff (pwr_init)
        (stalled && !bus_ack) |=> stalled && $stable(upc));

    // R6
    p_wait_release_r6: assert property (@(posedge clk) disable iff (pwr_init)
        (stalled && bus_ack) |=> !stalled && upc == $past(nxt_addr));

    // R7
    p_poll_to_service_r7: assert property (@(posedge clk) disable iff (pwr_init)
        (st_run && upc == '0 && |flags) |=> upc[AW-1:IW] == SVC_BASE[AW-1:IW]);
endmodule

bind useq_top useq_chk #(
    .AW(AW), .NFLAG(NFLAG), .INIT_ADDR(INIT_ADDR), .SVC_BASE(SVC_BASE)
) u_chk (
    .clk(clk), .pwr_init(pwr_init), .nxt_addr(nxt_addr), .br_sel(br_sel),
    .flags(flags), .bus_ack(bus_ack), .upc(upc), .stalled(stalled), .st_run(st_run)
);

// File: tb/useq_top_test.sv
`timescale 1ns/1ps
module useq_top_test;
    logic       clk = 1'b0;
    logic       pwr_init = 1'b1;
    logic [8:0] nxt_addr = '0;
    logic [1:0] br_sel = 2'b00;
    logic       test_in = 1'b0;
    logic [8:0] disp_val = '0;
    logic [2:0] flags = '0;
    logic       bus_ack = 1'b0;
    logic [8:0] upc;
    logic       stalled;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [8:0] e_upc;
        logic       e_stl;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz

    useq_top uut (
        .clk(clk), .pwr_init(pwr_init), .nxt_addr(nxt_addr), .br_sel(br_sel),
        .test_in(test_in), .disp_val(disp_val), .flags(flags), .bus_ack(bus_ack),
        .upc(upc), .stalled(stalled)
    );

    // Driver: present one microword and push the expected state after the edge.
    task automatic step(input logic [1:0] b, input logic [8:0] n, input logic t,
                        input logic [8:0] d, input logic [2:0] f, input logic a,
                        input logic ini, input logic [8:0] eu, input logic es,
                        input string tag);
        exp_t it;
        @(negedge clk);
        br_sel = b; nxt_addr = n; test_in = t; disp_val = d;
        flags = f; bus_ack = a; pwr_init = ini;
        it.e_upc = eu; it.e_stl = es; it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            n_chk++;
            if (upc !== it.e_upc || stalled !== it.e_stl) begin
                n_bad++;
                $display("FAIL %s: upc=%h stalled=%b expected upc=%h stalled=%b",
                         it.tag, upc, stalled, it.e_upc, it.e_stl);
            end
        end
    end

    bit finished = 0;
    initial begin
        #200000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(2'b00, 9'o016, 0, 9'h000, 3'b000, 0, 1, 9'o001, 0, "R1 init");
        step(2'b00, 9'o016, 0, 9'h000, 3'b000, 0, 1, 9'o001, 0, "R1 init hold");
        step(2'b00, 9'o016, 0, 9'h000, 3'b000, 0, 0, 9'o001, 0, "R1 first step after release");
        // R2 goto, test and dispatch inputs ignored
        step(2'b00, 9'o016, 1, 9'h1FF, 3'b000, 0, 0, 9'o016, 0, "R2 goto ignores test/disp");
        // R6 fetch waits for ack
        step(2'b11, 9'o015, 0, 9'h000, 3'b000, 0, 0, 9'o016, 1, "R6 fetch no ack");
        step(2'b11, 9'o015, 0, 9'h000, 3'b000, 0, 0, 9'o016, 1, "R6 still waiting");
        step(2'b11, 9'o015, 0, 9'h000, 3'b000, 1, 0, 9'o015, 0, "R6 ack releases");
        // R4 dispatch
        step(2'b10, 9'o040, 0, 9'o004, 3'b000, 0, 0, 9'o044, 0, "R4 dispatch overlay");
        step(2'b00, 9'o000, 0, 9'h000, 3'b000, 0, 0, 9'o000, 0, "R2 return to 000");
        // R7 poll with no flags follows microword
        step(2'b00, 9'o016, 0, 9'h000, 3'b000, 0, 0, 9'o016, 0, "R7 poll no flags");
        // R5 fetch with ack already present
        step(2'b11, 9'o015, 0, 9'h000, 3'b000, 1, 0, 9'o015, 0, "R5 fetch ack present");
        // R3 test branch taken and not taken
        step(2'b01, 9'o040, 1, 9'h000, 3'b000, 0, 0, 9'o041, 0, "R3 test true");
        step(2'b01, 9'o000, 0, 9'h000, 3'b000, 0, 0, 9'o000, 0, "R3 test false");
        // R7 priority
        step(2'b00, 9'o016, 0, 9'h000, 3'b110, 0, 0, 9'h101, 0, "R7 lowest flag is 1");
        step(2'b00, 9'o000, 0, 9'h000, 3'b001, 0, 0, 9'o000, 0, "R7 flags ignored off 000");
        step(2'b11, 9'o016, 0, 9'h000, 3'b100, 0, 0, 9'h102, 0, "R7 overrides fetch");
        step(2'b00, 9'o000, 0, 9'h000, 3'b000, 0, 0, 9'o000, 0, "R2 back to poll");
        step(2'b00, 9'o016, 0, 9'h000, 3'b111, 0, 0, 9'h100, 0, "R7 flag 0 wins");
        step(2'b10, 9'o040, 0, 9'o041, 3'b000, 0, 0, 9'o041, 0, "R4 overlapping bits");
        step(2'b00, 9'o016, 0, 9'h000, 3'b000, 0, 0, 9'o016, 0, "R2 goto 016");
        // R8 init during wait
        step(2'b11, 9'o015, 0, 9'h000, 3'b000, 0, 0, 9'o016, 1, "R6 wait again");
        step(2'b11, 9'o015, 0, 9'h000, 3'b000, 0, 1, 9'o001, 0, "R8 init aborts wait");
        step(2'b00, 9'o016, 0, 9'h000, 3'b000, 1, 0, 9'o001, 0, "R8 hold after release");
        step(2'b00, 9'o016, 0, 9'h000, 3'b000, 1, 0, 9'o016, 0, "R8 resumes");
        while (sb.size() > 0) @(posedge clk);
        @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule